// File: doc/BRIEF.md
# Configurable Fabric I/O Cell

This block is one pad cell of a programmable logic fabric. Static configuration bits set every choice it makes. The cell passes a data bit from the routing array to a pad and a data bit from the pad back to the array. It holds a single storage flop, and configuration places that flop on the pad-output path, on the pad-input path, or on neither. Either path that does not use the flop is a plain wire.

The pad driver enable comes from one of eight sources: the four global control lines, the two local output-control lines, a constant high or a constant low. A second flop can optionally retime the enable. Both flops share one clock, taken from one of four global clocks, with a per-cell choice of rising or falling edge. Both flops also share a selectable asynchronous reset and a selectable clock enable.

The pad is modelled as separate drive, enable and sense signals, plus a flag that shows when something outside drives the pad. When nobody drives the pad, a keeper returns the last driven level instead of a floating value.

Top module: `pio_cell`

## Requirements
- R1: The 13-bit `cfg` word holds these fields: bits [2:0] enable source, [4:3] clock select, [5] clock invert, [7:6] flop placement, [8] retimed enable, [10:9] reset source, [12:11] clock-enable source.
- R2: Enable source codes 0 to 3 pick `gctl[0]` to `gctl[3]`, 4 picks `lctl[0]`, 5 picks `lctl[1]`, 6 is constant 1 and 7 is constant 0. With bit 8 clear, `pad_oe` follows the chosen source without delay.
- R3: Clock select code n clocks the flops from `gclk[n]`. Edges on the other global clocks capture nothing.
- R4: With clock invert set, the flops capture on the falling edge of the chosen clock and ignore its rising edge.
- R5: Placement 2 (output) drives `pad_o` from the flop, which captures `from_fabric` on the active edge. `to_fabric` shows the pad level without delay.
- R6: Placement 1 (input) makes the flop capture the pad level and drives `to_fabric` from the flop. `pad_o` equals `from_fabric` without delay.
- R7: Placement 0 and the rejected code 3 leave both paths unregistered: `pad_o` equals `from_fabric` and `to_fabric` equals the pad level.
- R8: Reset source codes are 0 none, 1 `gctl[0]`, 2 `gctl[1]`, 3 `lctl[0]`. A high reset clears the data flop and the enable flop to 0 at once, without waiting for a clock.
- R9: Clock-enable source codes are 0 always on, 1 `gctl[2]`, 2 `gctl[3]`, 3 `lctl[1]`. While the chosen line is low, both flops keep their values across active edges.
- R10: With bit 8 set, `pad_oe` is the chosen enable source as captured on the last active edge.
- R11: The pad level is `pad_o` while `pad_oe` is high, otherwise `pad_i` while `pad_i_drv` is high, otherwise the last level from either driver. `pad_i` changes while nobody drives the pad have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gclk | input | 4 | Global clocks |
| gctl | input | 4 | Global control lines |
| lctl | input | 2 | Local output-control lines |
| cfg | input | 13 | Static configuration word |
| from_fabric | input | 1 | Data from the routing array toward the pad |
| to_fabric | output | 1 | Data from the pad toward the routing array |
| pad_o | output | 1 | Pad drive value |
| pad_oe | output | 1 | Pad driver enable |
| pad_i | input | 1 | Level applied to the pad from outside |
| pad_i_drv | input | 1 | High while an outside driver is active |

## Verification
Results on the unregistered paths (the enable mux, the bypassed data paths and the keeper) are due at once, so the bench samples them 1 ns after it changes the inputs. A registered result is due at the first active edge of the chosen clock. The bench checks it twice: once after the stimulus and before that edge, expecting the old value, and again 1 ns after the edge, expecting the new one. Edges are taken from the configured clock and polarity, so an edge on an unselected clock or of the wrong polarity can be shown to leave the output unchanged. Reset is asynchronous, so its effect is sampled 1 ns after the reset line rises, with no clock edge in between.

// File: rtl/pio_cell.sv
module pio_cell (
  input  logic [3:0]  gclk,
  input  logic [3:0]  gctl,
  input  logic [1:0]  lctl,
  input  logic [12:0] cfg,
  input  logic        from_fabric,
  output logic        to_fabric,
  output logic        pad_o,
  output logic        pad_oe,
  input  logic        pad_i,
  input  logic        pad_i_drv
);

  localparam logic [1:0] PLACE_IN  = 2'd1;
  localparam logic [1:0] PLACE_OUT = 2'd2;

  logic [2:0] oe_sel;
  logic [1:0] clk_sel, place, rst_sel, ce_sel;
  logic       clk_inv, oe_regd;

  assign oe_sel  = cfg[2:0];
  assign clk_sel = cfg[4:3];
  assign clk_inv = cfg[5];
  assign place   = cfg[7:6];
  assign oe_regd = cfg[8];
  assign rst_sel = cfg[10:9];
  assign ce_sel  = cfg[12:11];

  logic reg_in, reg_out;
  assign reg_in  = (place == PLACE_IN);
  assign reg_out = (place == PLACE_OUT);

  logic oe_src, reg_rst, reg_ce, reg_clk;

  always_comb begin
    case (oe_sel)
      3'd0, 3'd1, 3'd2, 3'd3: oe_src = gctl[oe_sel[1:0]];
      3'd4:                   oe_src = lctl[0];
      3'd5:                   oe_src = lctl[1];
      3'd6:                   oe_src = 1'b1;
      default:                oe_src = 1'b0;
    endcase
  end

  always_comb begin
    case (rst_sel)
      2'd0:    reg_rst = 1'b0;
      2'd1:    reg_rst = gctl[0];
      2'd2:    reg_rst = gctl[1];
      default: reg_rst = lctl[0];
    endcase
  end

  always_comb begin
    case (ce_sel)
      2'd0:    reg_ce = 1'b1;
      2'd1:    reg_ce = gctl[2];
      2'd2:    reg_ce = gctl[3];
      default: reg_ce = lctl[1];
    endcase
  end

  assign reg_clk = gclk[clk_sel] ^ clk_inv;

  logic q, oe_q, held, live, pad_level;

  assign pad_oe = oe_regd ? oe_q : oe_src;
  assign pad_o  = reg_out ? q : from_fabric;
  assign live   = pad_oe ? pad_o : pad_i;

  always_latch begin
    if (pad_oe || pad_i_drv) held = live;
  end

  assign pad_level = (pad_oe || pad_i_drv) ? live : held;
  assign to_fabric = reg_in ? q : pad_level;

  always_ff @(posedge reg_clk or posedge reg_rst) begin
    if (reg_rst) begin
      q    <= 1'b0;
      oe_q <= 1'b0;
    end else if (reg_ce) begin
      q    <= reg_in ? pad_level : from_fabric;
      oe_q <= oe_src;
    end
  end

  // R8
  rst_clear_chk: assert property (@(posedge reg_clk) reg_rst |-> (q == 1'b0 && oe_q == 1'b0));

  // R9
  ce_hold_chk: assert property (@(posedge reg_clk) disable iff (reg_rst)
    !reg_ce |=> ($stable(q) && $stable(oe_q)));

  // R7
  comb_out_chk: assert property (@(posedge gclk[0]) disable iff (reg_rst)
    !reg_out |-> (pad_o == from_fabric));

  // R2
  oe_off_chk: assert property (@(posedge gclk[0]) disable iff (reg_rst)
    (!oe_regd && oe_sel == 3'd7) |-> !pad_oe);

  // R11
  keeper_chk: assert property (@(posedge gclk[0]) disable iff (reg_rst)
    (!reg_in && $stable(cfg) && !pad_oe && !pad_i_drv && $past(!pad_oe && !pad_i_drv))
    |-> $stable(to_fabric));

endmodule

// File: tb/tb_pio_cell.sv
`timescale 1ns/1ps
module tb_pio_cell;
  logic c0 = 0, c1 = 0, c2 = 0, c3 = 0;
  logic [3:0]  gclk;
  logic [3:0]  gctl = 4'b1100;
  logic [1:0]  lctl = 2'b10;
  logic [12:0] cfg = '0;
  logic from_fabric = 0, pad_i = 0, pad_i_drv = 0;
  logic to_fabric, pad_o, pad_oe;
  int checks = 0, failures = 0;

  assign gclk = {c3, c2, c1, c0};
  always #2.5 c0 = ~c0;
  always #4   c1 = ~c1;
  always #6   c2 = ~c2;
  always #7   c3 = ~c3;

  pio_cell dut (.gclk(gclk), .gctl(gctl), .lctl(lctl), .cfg(cfg),
    .from_fabric(from_fabric), .to_fabric(to_fabric), .pad_o(pad_o),
    .pad_oe(pad_oe), .pad_i(pad_i), .pad_i_drv(pad_i_drv));

  // R1 field layout
  function automatic logic [12:0] mk(input int oe, input int ck, input int inv,
      input int pl, input int oer, input int rs, input int ce);
    return {ce[1:0], rs[1:0], oer[0], pl[1:0], inv[0], ck[1:0], oe[2:0]};
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic [3:0] g;
    g = {c3, c2, c1, c0};
    if (cfg[5]) begin
      case (cfg[4:3])
        2'd0: @(negedge c0);
        2'd1: @(negedge c1);
        2'd2: @(negedge c2);
        default: @(negedge c3);
      endcase
    end else begin
      case (cfg[4:3])
        2'd0: @(posedge c0);
        2'd1: @(posedge c1);
        2'd2: @(posedge c2);
        default: @(posedge c3);
      endcase
    end
    #1;
  endtask

  task automatic do_reset(input logic [12:0] c);
    gctl = 4'b1100; lctl = 2'b10; pad_i_drv = 0;
    cfg = '0; tick();
    cfg = c; #1;
    gctl[0] = 1; #1; gctl[0] = 0; #1;
  endtask

  task automatic t_oe();
    logic [3:0] gp;
    logic [1:0] lp;
    cfg = mk(0, 0, 0, 0, 0, 0, 0); tick();
    for (int p = 0; p < 2; p++) begin
      gp = p ? 4'b1010 : 4'b0101;
      lp = p ? 2'b01 : 2'b10;
      gctl = gp; lctl = lp;
      for (int s = 0; s < 8; s++) begin
        logic e;
        cfg = mk(s, 0, 0, 0, 0, 0, 0); #1;
        e = (s < 4) ? gp[s] : (s == 4) ? lp[0] : (s == 5) ? lp[1] : (s == 6);
        chk("R1/R2 oe source", pad_oe, e);
      end
    end
  endtask

  task automatic t_reset();
    do_reset(mk(6, 0, 0, 2, 1, 1, 0));
    chk("R8 flop after reset", pad_o, 0);
    from_fabric = 1; tick();
    chk("R5 captured", pad_o, 1);
    chk("R10 oe flop set", pad_oe, 1);
    gctl[0] = 1; #1;
    chk("R8 async clear data", pad_o, 0);
    chk("R8 async clear oe", pad_oe, 0);
    tick();
    chk("R8 held in reset", pad_o, 0);
    gctl[0] = 0;
    cfg = mk(6, 0, 0, 2, 1, 3, 0); tick();
    chk("R5 capture again", pad_o, 1);
    lctl[0] = 1; #1;
    chk("R8 reset from lctl0", pad_o, 0);
    lctl[0] = 0; #1;
  endtask

  task automatic t_out_rise();
    do_reset(mk(6, 0, 0, 2, 0, 1, 0));
    from_fabric = 1; #0.2;
    chk("R5 before edge", pad_o, 0);
    tick();
    chk("R5 after edge", pad_o, 1);
    chk("R5 pad level to fabric", to_fabric, 1);
    from_fabric = 0; tick();
    chk("R5 capture 0", pad_o, 0);
  endtask

  task automatic t_fall();
    do_reset(mk(6, 1, 1, 2, 0, 1, 0));
    @(negedge c1); #1;
    from_fabric = 1;
    @(posedge c1); #1;
    chk("R4 rising edge ignored", pad_o, 0);
    @(negedge c1); #1;
    chk("R4 falling edge captures", pad_o, 1);
    from_fabric = 0;
  endtask

  task automatic t_clksel();
    do_reset(mk(6, 3, 0, 2, 0, 1, 0));
    @(posedge c3); #1;
    from_fabric = 1;
    @(posedge c0); #1;
    chk("R3 other clock ignored", pad_o, 0);
    @(posedge c3); #1;
    chk("R3 selected clock captures", pad_o, 1);
    from_fabric = 0;
  endtask

  task automatic t_in();
    do_reset(mk(7, 0, 0, 1, 0, 1, 0));
    pad_i_drv = 1; pad_i = 1; from_fabric = 1; #0.2;
    chk("R6 before edge", to_fabric, 0);
    chk("R6 output unregistered", pad_o, 1);
    tick();
    chk("R6 captured pad", to_fabric, 1);
    pad_i = 0; #0.2;
    chk("R6 holds until edge", to_fabric, 1);
    tick();
    chk("R6 captured 0", to_fabric, 0);
    pad_i_drv = 0; from_fabric = 0;
  endtask

  task automatic t_none();
    for (int pl = 0; pl < 4; pl += 3) begin
      do_reset(mk(6, 0, 0, pl, 0, 1, 0));
      from_fabric = 1; #1;
      chk("R7 pad_o follows", pad_o, 1);
      chk("R7 to_fabric follows", to_fabric, 1);
      tick();
      from_fabric = 0; #1;
      chk("R7 pad_o follows 0", pad_o, 0);
      chk("R7 to_fabric follows 0", to_fabric, 0);
    end
  endtask

  task automatic t_ce();
    do_reset(mk(6, 0, 0, 2, 1, 1, 1));
    from_fabric = 1; tick();
    chk("R9 enabled capture", pad_o, 1);
    gctl[2] = 0; from_fabric = 0;
    cfg = mk(7, 0, 0, 2, 1, 1, 1); tick(); tick();
    chk("R9 data held", pad_o, 1);
    chk("R9 oe flop held", pad_oe, 1);
    gctl[2] = 1; tick();
    chk("R9 data resumes", pad_o, 0);
    chk("R9 oe resumes", pad_oe, 0);
    cfg = mk(6, 0, 0, 2, 0, 1, 3);
    lctl[1] = 0; from_fabric = 1; tick();
    chk("R9 lctl1 holds", pad_o, 0);
    lctl[1] = 1; tick();
    chk("R9 lctl1 enables", pad_o, 1);
    from_fabric = 0;
  endtask

  task automatic t_oereg();
    do_reset(mk(4, 0, 0, 0, 1, 1, 0));
    lctl[0] = 1; #0.2;
    chk("R10 not before edge", pad_oe, 0);
    tick();
    chk("R10 after edge", pad_oe, 1);
    lctl[0] = 0; #0.2;
    chk("R10 stays until edge", pad_oe, 1);
    tick();
    chk("R10 cleared", pad_oe, 0);
  endtask

  task automatic t_hold();
    do_reset(mk(4, 0, 0, 0, 0, 1, 0));
    lctl[0] = 1; from_fabric = 1; tick();
    chk("R11 driven level", to_fabric, 1);
    lctl[0] = 0; tick();
    chk("R11 kept after release", to_fabric, 1);
    from_fabric = 0; tick();
    chk("R11 undriven data ignored", to_fabric, 1);
    pad_i = 0; pad_i_drv = 1; tick();
    chk("R11 outside driver", to_fabric, 0);
    pad_i_drv = 0; tick();
    chk("R11 kept outside level", to_fabric, 0);
    pad_i = 1; tick();
    chk("R11 pad_i ignored while floating", to_fabric, 0);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #3;
    t_oe();
    t_reset();
    t_out_rise();
    t_fall();
    t_clksel();
    t_in();
    t_none();
    t_ce();
    t_oereg();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule